// File: doc/BRIEF.md
# Translation Cache with Page Shootdown

This block holds a small, fully associative set of finished address translations, each mapping a 20-bit virtual page number to a 20-bit physical page number together with a read permission and a write permission. Pages are 4 KB. A lookup presents a full 32-bit virtual address. One clock later the block reports hit or miss, the physical address and the permissions. The physical address is formed from the stored physical page and the untouched low 12 bits of the request.

Entries arrive through a fill port, which places each new page into the slot named by a round-robin pointer. There are two ways to remove translations from the control side. A single-page shootdown takes a full virtual address and removes the entry holding that page. A flush removes every entry in one cycle. The page-table walker that produces fills is outside this block, and so is the register decode that drives the shootdown and flush strobes. A walker is expected to flush the whole cache after it services a fault and before it acknowledges the fault.

Top module: `xlat_cache`

## Requirements
- R1: A lookup (`lk_req` high) made in a cycle with no invalidation gives `rsp_valid` high in the next cycle. On a hit, `rsp_paddr` is {stored physical page, `lk_vaddr[11:0]`} and `rsp_rd`/`rsp_wr` are the stored permissions.
- R2: Only `lk_vaddr[31:12]` takes part in matching. On a miss, `rsp_hit`, `rsp_rd` and `rsp_wr` are 0 and `rsp_paddr` is 0.
- R3: A fill of a page that is not resident writes the slot at the round-robin pointer. The pointer is 0 after reset and steps by one, wrapping from 7 to 0, on each such accepted fill.
- R4: A fill of a page that is already resident rewrites that entry in place and leaves the pointer unchanged, so at most one entry ever matches a page.
- R5: `zap_one_en` invalidates the entry whose page equals `zap_vaddr[31:12]`. The low 12 bits of `zap_vaddr` are ignored, and every other entry is left intact.
- R6: `zap_all_en` invalidates every entry within one cycle.
- R7: A lookup made in the same cycle as either invalidation is dropped, and `rsp_valid` is low in the next cycle.
- R8: A fill is discarded and the pointer holds if it arrives with `zap_all_en`, or if it arrives with `zap_one_en` and either the shootdown page equals the fill page or the slot the fill would write currently holds the shootdown page.
- R9: After reset every entry is invalid and `rsp_valid` is low.
- R10: A lookup sees the contents from before any fill made in the same cycle. A fill is visible to lookups made from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_en | input | 1 | Insert a translation |
| fill_vpn | input | 20 | Virtual page number to insert |
| fill_ppn | input | 20 | Physical page number to insert |
| fill_rd | input | 1 | Read permission of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| zap_one_en | input | 1 | Invalidate the page of `zap_vaddr` |
| zap_vaddr | input | 32 | Virtual address whose page is shot down |
| zap_all_en | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup matched an entry |
| rsp_paddr | output | 32 | Translated physical address, 0 on miss |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |

## Verification
Each lookup result is due exactly one clock after the request, because only the response register lies on that path. Fills, shootdowns and flushes act at the clock edge of the cycle in which they are presented, so their effect first appears in the answer to a lookup made in the following cycle. This gives a two-cycle gap from a fill to a hit. The bench drives every input just after a falling edge, updates its own table model at the rising edge using the table as it stood before that edge, and compares the response at the next falling edge. Sweeps look up every page the model has ever held after each phase, so evictions, in-place rewrites and discarded fills all become visible at the ports.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int XC_ENTRIES = 8;
  localparam int XC_VA_W    = 32;
  localparam int XC_PAGE_W  = 12;
  localparam int XC_PPN_W   = 20;

  typedef struct packed {
    logic rd;
    logic wr;
  } xc_perm_t;
endpackage

// File: rtl/xc_tag_match.sv
module xc_tag_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0]       valid,
  input  logic [N*VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]   key,
  output logic [N-1:0]       hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid[i] && (tags[i*VPN_W +: VPN_W] == key);
  end
endmodule

// File: rtl/xc_victim_ptr.sv
module xc_victim_ptr #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr,
  output logic [N-1:0]     ptr_oh
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  assign ptr    = ptr_q;
  assign ptr_oh = N'(1) << ptr_q;
endmodule

// File: rtl/xc_entry_store.sv
module xc_entry_store
  import xc_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       wr_oh,
  input  logic [N-1:0]       clr,
  input  logic [VPN_W-1:0]   w_vpn,
  input  logic [PPN_W-1:0]   w_ppn,
  input  xc_perm_t           w_perm,
  output logic [N-1:0]       valid,
  output logic [N*VPN_W-1:0] tags,
  output logic [N*PPN_W-1:0] ppns,
  output logic [N*2-1:0]     perms
);
  logic [N-1:0] valid_q, valid_d;

  // a slot never receives a write and a clear together (control guarantees it)
  always_comb begin
    valid_d = (valid_q & ~clr) | wr_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    xc_perm_t         perm_q;

    always_ff @(posedge clk) begin
      if (wr_oh[i]) begin
        vpn_q  <= w_vpn;
        ppn_q  <= w_ppn;
        perm_q <= w_perm;
      end
    end

    assign tags[i*VPN_W +: VPN_W] = vpn_q;
    assign ppns[i*PPN_W +: PPN_W] = ppn_q;
    assign perms[i*2 +: 2]        = perm_q;
  end

  assign valid = valid_q;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int N      = XC_ENTRIES,
  parameter int VA_W   = XC_VA_W,
  parameter int PAGE_W = XC_PAGE_W,
  parameter int PPN_W  = XC_PPN_W,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PA_W  = PPN_W + PAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             zap_one_en,
  input  logic [VA_W-1:0]  zap_vaddr,
  input  logic             zap_all_en,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_rd,
  output logic             rsp_wr
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]       valid_q;
  logic [N*VPN_W-1:0] tag_flat;
  logic [N*PPN_W-1:0] ppn_flat;
  logic [N*2-1:0]     perm_flat;

  logic [N-1:0]       lk_hit, zap_hit_raw, zap_hit, fill_hit;
  logic [N-1:0]       fill_tgt, wr_oh, clr;
  logic [IDX_W-1:0]   ptr;
  logic [N-1:0]       ptr_oh;
  logic [VPN_W-1:0]   zap_vpn, lk_vpn;
  logic               fill_block, fill_do, fill_adv, lk_take;
  xc_perm_t           w_perm;

  assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_W];
  assign zap_vpn = zap_vaddr[VA_W-1:PAGE_W];

  xc_tag_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(tag_flat), .key(lk_vpn), .hit(lk_hit));
  xc_tag_match #(.N(N), .VPN_W(VPN_W)) u_zap_match (
    .valid(valid_q), .tags(tag_flat), .key(zap_vpn), .hit(zap_hit_raw));
  xc_tag_match #(.N(N), .VPN_W(VPN_W)) u_fill_match (
    .valid(valid_q), .tags(tag_flat), .key(fill_vpn), .hit(fill_hit));

  xc_victim_ptr #(.N(N), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(fill_adv), .ptr(ptr), .ptr_oh(ptr_oh));

  // ---- update control: invalidation outranks fill ----
  always_comb begin
    zap_hit    = zap_hit_raw & {N{zap_one_en}};
    fill_tgt   = (|fill_hit) ? fill_hit : ptr_oh;
    fill_block = zap_all_en |
                 (zap_one_en & ((zap_vpn == fill_vpn) | (|(fill_tgt & zap_hit_raw))));
    fill_do    = fill_en & ~fill_block;
    wr_oh      = {N{fill_do}} & fill_tgt;
    clr        = zap_all_en ? {N{1'b1}} : zap_hit;
    fill_adv   = fill_do & ~(|fill_hit);
    w_perm.rd  = fill_rd;
    w_perm.wr  = fill_wr;
  end

  xc_entry_store #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_oh(wr_oh), .clr(clr),
    .w_vpn(fill_vpn), .w_ppn(fill_ppn), .w_perm(w_perm),
    .valid(valid_q), .tags(tag_flat), .ppns(ppn_flat), .perms(perm_flat));

  // ---- lookup read path ----
  logic [PPN_W-1:0] sel_ppn;
  logic [1:0]       sel_perm;

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_hit[i]) begin
        sel_ppn  = sel_ppn  | ppn_flat[i*PPN_W +: PPN_W];
        sel_perm = sel_perm | perm_flat[i*2 +: 2];
      end
    end
  end

  logic            rsp_valid_q, rsp_valid_d;
  logic            rsp_hit_q,   rsp_hit_d;
  logic [PA_W-1:0] rsp_paddr_q, rsp_paddr_d;
  logic            rsp_rd_q,    rsp_rd_d;
  logic            rsp_wr_q,    rsp_wr_d;

  always_comb begin
    lk_take     = lk_req & ~zap_one_en & ~zap_all_en;
    rsp_valid_d = lk_take;
    rsp_hit_d   = lk_take & (|lk_hit);
    rsp_paddr_d = rsp_hit_d ? {sel_ppn, lk_vaddr[PAGE_W-1:0]} : '0;
    rsp_rd_d    = rsp_hit_d & sel_perm[1];
    rsp_wr_d    = rsp_hit_d & sel_perm[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_rd_q    <= 1'b0;
      rsp_wr_q    <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_paddr_q <= rsp_paddr_d;
      rsp_rd_q    <= rsp_rd_d;
      rsp_wr_q    <= rsp_wr_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_paddr = rsp_paddr_q;
  assign rsp_rd    = rsp_rd_q;
  assign rsp_wr    = rsp_wr_q;
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int N      = 8,
  parameter int PAGE_W = 12,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int IDX_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             zap_one_en,
  input logic             zap_all_en,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_rd,
  input logic             rsp_wr,
  input logic [N-1:0]     lk_hit,
  input logic [N-1:0]     valid_q,
  input logic             fill_adv,
  input logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  // R7
  a_r7_lookup_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (zap_one_en || zap_all_en) |=> !rsp_valid);

  // R1
  a_r1_response_due: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !zap_one_en && !zap_all_en) |=> rsp_valid);

  // R1
  a_r1_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !zap_one_en && !zap_all_en) |=>
      (!rsp_hit || rsp_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));

  // R2
  a_r2_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_rd && !rsp_wr));

  // R6
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    zap_all_en |=> (valid_q == '0));

  // R4
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit));

  // R3
  a_r3_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    fill_adv |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  // R3
  a_r3_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_adv |=> $stable(ptr));
endmodule

bind xlat_cache xc_checker #(
  .N(N), .PAGE_W(PAGE_W), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
  .zap_one_en(zap_one_en), .zap_all_en(zap_all_en),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
  .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .lk_hit(lk_hit), .valid_q(valid_q),
  .fill_adv(fill_adv), .ptr(ptr)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  logic        clk, rst_n;
  logic        lk_req, fill_en, fill_rd, fill_wr, zap_one_en, zap_all_en;
  logic [31:0] lk_vaddr, zap_vaddr;
  logic [19:0] fill_vpn, fill_ppn;
  logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr;
  logic [31:0] rsp_paddr;

  int tests, fails;
  bit done;

  xlat_cache u0 (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .zap_one_en(zap_one_en),
    .zap_vaddr(zap_vaddr), .zap_all_en(zap_all_en), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // table model built from the requirements
  bit          mv[8];
  logic [19:0] mvpn[8], mppn[8];
  bit          mrd[8], mwr[8];
  int          mptr;
  logic [19:0] seen[$];

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, let the edge act, compare the response
  task automatic cyc(input string req, input bit lk, input logic [31:0] lva,
                     input bit fe, input logic [19:0] fv, input logic [19:0] fp,
                     input bit frd, input bit fwr,
                     input bit zo, input logic [31:0] zva, input bit za);
    logic [35:0] exp;
    int fm, tgt;
    bit blk;
    lk_req = lk; lk_vaddr = lva; fill_en = fe; fill_vpn = fv; fill_ppn = fp;
    fill_rd = frd; fill_wr = fwr; zap_one_en = zo; zap_vaddr = zva; zap_all_en = za;
    exp = '0;
    if (lk && !zo && !za) begin
      exp[35] = 1'b1;
      for (int i = 0; i < 8; i++)
        if (mv[i] && mvpn[i] == lva[31:12])
          exp = {1'b1, 1'b1, mrd[i], mwr[i], mppn[i], lva[11:0]};
    end
    @(posedge clk);
    fm = -1;
    for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == fv) fm = i;
    tgt = (fm >= 0) ? fm : mptr;
    blk = za || (zo && (zva[31:12] == fv || (mv[tgt] && mvpn[tgt] == zva[31:12])));
    for (int i = 0; i < 8; i++)
      if (za || (zo && mvpn[i] == zva[31:12])) mv[i] = 1'b0;
    if (fe && !blk) begin
      mv[tgt] = 1'b1; mvpn[tgt] = fv; mppn[tgt] = fp; mrd[tgt] = frd; mwr[tgt] = fwr;
      if (fm < 0) mptr = (mptr + 1) % 8;
      seen.push_back(fv);
    end
    @(negedge clk);
    lk_req = 0; fill_en = 0; zap_one_en = 0; zap_all_en = 0;
    chk({rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_paddr} == exp, req,
        {rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_paddr}, exp);
  endtask

  task automatic look(input string req, input logic [31:0] va);
    cyc(req, 1, va, 0, '0, '0, 0, 0, 0, '0, 0);
  endtask

  task automatic fill(input string req, input logic [19:0] v, input logic [19:0] p, input bit r, input bit w);
    cyc(req, 0, '0, 1, v, p, r, w, 0, '0, 0);
  endtask

  task automatic sweep(input string req);
    foreach (seen[k]) look(req, {seen[k], 12'((k * 12'h1F3) ^ 12'h5A5)});
  endtask

  initial begin
    tests = 0; fails = 0; done = 0; mptr = 0;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mvpn[i] = '0; mppn[i] = '0; mrd[i] = 0; mwr[i] = 0; end
    lk_req = 0; lk_vaddr = '0; fill_en = 0; fill_vpn = '0; fill_ppn = '0;
    fill_rd = 0; fill_wr = 0; zap_one_en = 0; zap_vaddr = '0; zap_all_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R9", {35'd0, rsp_valid}, 36'd0);
    // R9 / R2: empty table misses whatever the offset
    look("R9", 32'h0000_0000);
    look("R2", 32'hFFFF_FFFF);
    look("R2", 32'h0123_4ABC);
    // R3: fill all eight slots
    for (int i = 0; i < 8; i++)
      fill("R3", 20'(i * 20'h111 + 3), 20'(20'hA0000 + i * 20'h101), i[0], i[1]);
    sweep("R1");
    look("R2", {20'hFFFFF, 12'h123});
    // R10: fill and lookup of a new page together -> miss, then hit
    cyc("R10", 1, {20'h55555, 12'h010}, 1, 20'h55555, 20'h12345, 1, 1, 0, '0, 0);
    look("R10", {20'h55555, 12'hFED});
    look("R3", {20'h00003, 12'h000}); // slot 0 evicted
    // R4: rewrite resident page in place, pointer unchanged
    fill("R4", 20'h00336, 20'h77777, 1, 0);
    look("R4", {20'h00336, 12'h444});
    fill("R4", 20'h66666, 20'h0BEEF, 0, 1);
    look("R4", {20'h00114, 12'h001}); // slot 1 evicted, not slot 2
    look("R4", {20'h00225, 12'h002});
    sweep("R3");
    // R7 + R5: shootdown with a lookup in the same cycle
    cyc("R7", 1, {20'h00558, 12'h000}, 0, '0, '0, 0, 0, 1, {20'h00558, 12'hABC}, 0);
    look("R5", {20'h00558, 12'h000});
    look("R5", {20'h00669, 12'h0F0});
    sweep("R5");
    // R8: fill of the page being shot down is discarded
    cyc("R8", 0, '0, 1, 20'h00669, 20'h11111, 1, 1, 1, {20'h00669, 12'h000}, 0);
    look("R8", {20'h00669, 12'h000});
    // R8: victim slot holds the shootdown page
    cyc("R8", 0, '0, 1, 20'hC0C0C, 20'h22222, 1, 0, 1, {mvpn[mptr], 12'h7FF}, 0);
    look("R8", {20'hC0C0C, 12'h000});
    fill("R8", 20'hD0D0D, 20'h33333, 0, 0);
    sweep("R8");
    // R6 + R8: flush with a fill and a lookup in the same cycle
    cyc("R6", 1, {20'hD0D0D, 12'h000}, 1, 20'hE0E0E, 20'h44444, 1, 1, 0, '0, 1);
    sweep("R6");
    // refill after flush, pointer continues round robin
    for (int i = 0; i < 10; i++)
      fill("R3", 20'(20'h80000 + i * 20'h1357), 20'(i * 20'h2468), i[1], i[0]);
    sweep("R3");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule